// File: doc/BRIEF.md
# Parallel Display Write Bridge

This block sits on a simple memory-mapped register bus as a write-only slave and converts each host store into one write transaction on a 16-bit 8080-style parallel bus feeding a display controller. The register offset selects what kind of transaction is produced. A store to the command register produces a command cycle, with the select line low and only the low byte meaningful. A store to the pixel register produces a data cycle, with the select line high and the full 16-bit RGB565 word.

A third register holds the display-enable bit. Writing it never produces a bus cycle. While a transaction is on the wire, the bridge raises a wait signal toward the host. Any store presented while that signal is high is dropped, and the host is expected to retry it. The panel-side chip select and the write strobe follow a fixed phase order: setup, strobe low, then hold. Data and the select line stay stable through the whole transaction and across the latching rising edge of the write strobe. The read strobe is tied inactive.

Top module: `lcd_write_bridge`

## Requirements
- R1: After reset, chip select, write strobe and read strobe are high, display enable is low and wait is low.
- R2: A host store at byte offset 0 produces one cycle with the select line low and the bus equal to {8'h00, wdata[7:0]}.
- R3: A host store at byte offset 4 produces one cycle with the select line high and the bus equal to wdata[15:0], passed unchanged (red in 15:11, green in 10:5, blue in 4:0).
- R4: Each cycle has three phases. First, chip select falls while the write strobe is still high, for one clock. Next, the write strobe is held low for exactly WR_LOW_CLKS clocks. Then the write strobe rises while chip select stays low for one more clock, after which chip select returns high.
- R5: The bus and the select line do not change while chip select is low.
- R6: Wait is high exactly while chip select is low, which is WR_LOW_CLKS+2 clocks per cycle, starting the clock after the store is accepted.
- R7: A host store presented while wait is high has no effect: it produces no cycle and leaves display enable unchanged.
- R8: A host store at byte offset 8 copies wdata[0] to display enable without producing a bus cycle. A store at byte offset 12 changes nothing.
- R9: The read strobe stays high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Host write request |
| bus_addr | input | 4 | Host byte address (bits 3:2 decoded) |
| bus_wdata | input | 32 | Host write data |
| bus_wait | output | 1 | High while a panel cycle is in progress |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_dc | output | 1 | Data (1) or command (0) select |
| lcd_wr_n | output | 1 | Write strobe, panel latches on its rising edge |
| lcd_rd_n | output | 1 | Read strobe, held high |
| lcd_on | output | 1 | Display enable |
| lcd_d | output | 16 | Panel data bus |

## Verification
The hardest situation to reach from the ports is a host store that arrives while a transaction is still on the wire, because a well-behaved host waits for the wait signal to drop. To get there, the stimulus deliberately ignores wait: right after a pixel store is accepted, it forces one pixel store and one enable store into the busy window. A scoreboard of expected panel cycles then exposes any extra cycle, and a later read of display enable shows whether the dropped store left a trace.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_t;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_CMD  = 2'd1,
      ACC_PIX  = 2'd2,
      ACC_CTRL = 2'd3
   } access_t;

   // word index (byte offset / 4) of each register
   localparam logic [1:0] IDX_CMD  = 2'd0;
   localparam logic [1:0] IDX_PIX  = 2'd1;
   localparam logic [1:0] IDX_CTRL = 2'd2;

endpackage

// File: rtl/lcdb_decode.sv
module lcdb_decode
   import lcdb_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              wr,
   input  logic              idle,
   input  logic [ADDR_W-1:0] addr,
   output access_t           kind
);

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("lcdb_decode: ADDR_W must be at least 4");
      end
   endgenerate

   logic [1:0] word_idx;
   assign word_idx = addr[3:2];

   always_comb begin
      kind = ACC_NONE;
      if (wr && idle) begin
         unique case (word_idx)
            IDX_CMD:  kind = ACC_CMD;
            IDX_PIX:  kind = ACC_PIX;
            IDX_CTRL: kind = ACC_CTRL;
            default:  kind = ACC_NONE;
         endcase
      end
   end

endmodule

// File: rtl/lcdb_sequencer.sv
module lcdb_sequencer
   import lcdb_pkg::*;
#(
   parameter int WR_LOW_CLKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic cs_n,
   output logic wr_n,
   output logic busy
);

   localparam int CNT_W = $clog2(WR_LOW_CLKS + 1) + 1;
   localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(WR_LOW_CLKS);

   generate
      if (WR_LOW_CLKS < 1) begin : g_bad_low
         $error("lcdb_sequencer: WR_LOW_CLKS must be at least 1");
      end
   endgenerate

   phase_t           phase;
   logic [CNT_W-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         low_cnt <= '0;
         cs_n    <= 1'b1;
         wr_n    <= 1'b1;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) begin
               phase <= PH_SETUP;
               cs_n  <= 1'b0;
            end
            PH_SETUP: begin
               phase   <= PH_STROBE;
               wr_n    <= 1'b0;
               low_cnt <= CNT_W'(1);
            end
            PH_STROBE: begin
               if (low_cnt == LOW_LAST) begin
                  phase <= PH_HOLD;
                  wr_n  <= 1'b1;
               end else begin
                  low_cnt <= low_cnt + 1'b1;
               end
            end
            PH_HOLD: begin
               phase <= PH_IDLE;
               cs_n  <= 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy = (phase != PH_IDLE);

   // independent width monitor for the strobe
   logic [CNT_W-1:0] low_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     low_run <= '0;
      else if (!wr_n) low_run <= low_run + 1'b1;
      else            low_run <= '0;
   end

   assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> (low_run == LOW_LAST));
   assert_strobe_inside_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> !cs_n);
   assert_setup_before_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> wr_n);
   assert_hold_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> !cs_n);

endmodule

// File: rtl/lcdb_payload.sv
module lcdb_payload #(
   parameter int HOST_W = 32,
   parameter int DATA_W = 16,
   parameter int CMD_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              is_pix,
   input  logic [HOST_W-1:0] wdata,
   output logic [DATA_W-1:0] bus_d,
   output logic              bus_dc
);

   generate
      if (HOST_W < DATA_W) begin : g_bad_host
         $error("lcdb_payload: HOST_W must cover DATA_W");
      end
      if (CMD_W > DATA_W || CMD_W < 1) begin : g_bad_cmd
         $error("lcdb_payload: CMD_W must be 1..DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] cmd_word;
   logic [DATA_W-1:0] pix_word;

   assign pix_word = wdata[DATA_W-1:0];

   generate
      if (CMD_W < DATA_W) begin : g_cmd_pad
         assign cmd_word = {{(DATA_W-CMD_W){1'b0}}, wdata[CMD_W-1:0]};
      end else begin : g_cmd_full
         assign cmd_word = wdata[DATA_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_d  <= '0;
         bus_dc <= 1'b0;
      end else if (load) begin
         bus_d  <= is_pix ? pix_word : cmd_word;
         bus_dc <= is_pix;
      end
   end

endmodule

// File: rtl/lcd_write_bridge.sv
module lcd_write_bridge
   import lcdb_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int HOST_W      = 32,
   parameter int DATA_W      = 16,
   parameter int CMD_W       = 8,
   parameter int WR_LOW_CLKS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [HOST_W-1:0] bus_wdata,
   output logic              bus_wait,
   output logic              lcd_cs_n,
   output logic              lcd_dc,
   output logic              lcd_wr_n,
   output logic              lcd_rd_n,
   output logic              lcd_on,
   output logic [DATA_W-1:0] lcd_d
);

   access_t kind;
   logic    busy;
   logic    start;

   lcdb_decode #(.ADDR_W(ADDR_W)) u_decode (
      .wr   (bus_wr),
      .idle (!busy),
      .addr (bus_addr),
      .kind (kind)
   );

   assign start = (kind == ACC_CMD) || (kind == ACC_PIX);

   lcdb_sequencer #(.WR_LOW_CLKS(WR_LOW_CLKS)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .cs_n  (lcd_cs_n),
      .wr_n  (lcd_wr_n),
      .busy  (busy)
   );

   lcdb_payload #(.HOST_W(HOST_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) u_payload (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start),
      .is_pix (kind == ACC_PIX),
      .wdata  (bus_wdata),
      .bus_d  (lcd_d),
      .bus_dc (lcd_dc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lcd_on <= 1'b0;
      else if (kind == ACC_CTRL) lcd_on <= bus_wdata[0];
   end

   assign bus_wait = busy;
   assign lcd_rd_n = 1'b1;

   assert_stable_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!lcd_cs_n && $past(!lcd_cs_n)) |-> ($stable(lcd_d) && $stable(lcd_dc)));
   assert_wait_tracks_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wait == !lcd_cs_n);
   assert_busy_drop_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wait && bus_wr) |=> $stable(lcd_on));
   assert_busy_drop_payload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wait && bus_wr) |=> ($stable(lcd_d) && $stable(lcd_dc)));
   assert_ctrl_no_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wait && bus_wr && bus_addr[3:2] == IDX_CTRL) |=> lcd_cs_n);

endmodule

// File: tb/test_lcd_write_bridge.sv
`timescale 1ns/1ps
module test_lcd_write_bridge;

   localparam int W = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_wait, lcd_cs_n, lcd_dc, lcd_wr_n, lcd_rd_n, lcd_on;
   logic [15:0] lcd_d;

   int checks = 0;
   int errors = 0;
   int pushed = 0;
   int seen = 0;
   int cs_falls = 0;
   bit done = 0;
   logic [16:0] exp_q[$];

   always #5 clk = ~clk;

   lcd_write_bridge #(.WR_LOW_CLKS(W)) i_lcd_write_bridge (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_wait(bus_wait), .lcd_cs_n(lcd_cs_n),
      .lcd_dc(lcd_dc), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
      .lcd_on(lcd_on), .lcd_d(lcd_d)
   );

   task automatic chk(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver: waits for idle, presents one store, records the expected panel cycle
   task automatic host_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      while (bus_wait) @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      if (a == 4'h0) begin exp_q.push_back({1'b0, 8'h00, d[7:0]}); pushed++; end
      if (a == 4'h4) begin exp_q.push_back({1'b1, d[15:0]});       pushed++; end
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   // store that ignores wait (expected to be dropped when busy)
   task automatic poke(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk);
      while (bus_wait) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor / scoreboard
   logic prev_wr = 1'b1, prev_cs = 1'b1, prev_wait = 1'b0;
   logic [16:0] held;
   int low_cnt = 0, wait_cnt = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_cs && !lcd_cs_n) begin
            cs_falls++;
            chk("R4 setup: strobe high at select fall", lcd_wr_n, lcd_wr_n, 1);
            held = {lcd_dc, lcd_d};
         end else if (!lcd_cs_n && !prev_cs && {lcd_dc, lcd_d} != held) begin
            chk("R5 payload changed during cycle", 0, {lcd_dc, lcd_d}, held);
         end
         if (!lcd_wr_n) low_cnt++;
         if (!prev_wr && lcd_wr_n) begin
            seen++;
            chk("R4 strobe low width", low_cnt == W, low_cnt, W);
            chk("R4 hold: select low at strobe rise", !lcd_cs_n, lcd_cs_n, 0);
            chk("R9 read strobe high", lcd_rd_n, lcd_rd_n, 1);
            if (exp_q.size() == 0) begin
               chk("R7 unexpected panel cycle", 0, {lcd_dc, lcd_d}, 0);
            end else begin
               logic [16:0] e;
               e = exp_q.pop_front();
               chk(e[16] ? "R3 data cycle select/bus" : "R2 command cycle select/bus",
                   {lcd_dc, lcd_d} == e, {lcd_dc, lcd_d}, e);
            end
            low_cnt = 0;
         end
         if (bus_wait) wait_cnt++;
         if (prev_wait && !bus_wait) begin
            chk("R6 wait width", wait_cnt == W + 2, wait_cnt, W + 2);
            wait_cnt = 0;
         end
         prev_wr = lcd_wr_n; prev_cs = lcd_cs_n; prev_wait = bus_wait;
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(10 * 50000);
      chk("watchdog expired", 0, 0, 1);
      finish_run();
   end

   initial begin
      int falls_before;
      repeat (3) @(negedge clk);
      chk("R1 reset select", lcd_cs_n, lcd_cs_n, 1);
      chk("R1 reset strobe", lcd_wr_n, lcd_wr_n, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 read strobe", lcd_rd_n, lcd_rd_n, 1);
      chk("R1 enable low", !lcd_on, lcd_on, 0);
      chk("R1 wait low", !bus_wait, bus_wait, 0);

      // R2 command with junk upper bits
      host_write(4'h0, 32'hABCD_122C);
      // R3 pixels: pure red, green, blue, white with junk upper half
      host_write(4'h4, 32'h5A5A_F800);
      host_write(4'h4, 32'h5A5A_07E0);
      host_write(4'h4, 32'h0000_001F);
      host_write(4'h4, 32'hFFFF_FFFF);
      host_write(4'h0, 32'h0000_0029);
      settle();

      // R7 stores while busy are dropped
      host_write(4'h4, 32'h0000_1234);
      poke(4'h4, 32'h0000_9999);
      poke(4'h8, 32'h0000_0001);
      settle();
      chk("R7 enable unchanged by dropped store", !lcd_on, lcd_on, 0);

      // R8 enable register and unused offset
      falls_before = cs_falls;
      host_write(4'h8, 32'h0000_0003);
      @(negedge clk);
      chk("R8 enable set", lcd_on, lcd_on, 1);
      chk("R8 no wait on enable store", !bus_wait, bus_wait, 0);
      host_write(4'hC, 32'h0000_0000);
      @(negedge clk);
      chk("R8 unused offset leaves enable", lcd_on, lcd_on, 1);
      host_write(4'h8, 32'h0000_0002);
      @(negedge clk);
      chk("R8 enable cleared by bit0", !lcd_on, lcd_on, 0);
      repeat (3) @(negedge clk);
      chk("R8 no panel cycle from register stores", cs_falls == falls_before, cs_falls, falls_before);

      host_write(4'h4, 32'h0000_A5A5);
      settle();
      chk("R7 scoreboard drained", exp_q.size() == 0, exp_q.size(), 0);
      chk("R7 cycle count", seen == pushed, seen, pushed);
      finish_run();
   end

endmodule